// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as packed BCD bytes. A one-cycle enable pulse, once per second, advances the time. The fields are seconds, minutes, hours, date, month, year, a two-digit century and a day-of-week counter. Hours can count in 24-hour form or in 12-hour form with a PM flag. Month lengths are handled in full. Every year divisible by four is a leap year, which is correct for the years up to 2099.

A host reaches the time through two buffers, so that its accesses never see a half-updated clock. A snapshot strobe copies every live field into a read latch in one cycle, and the host then reads single bytes from that latch while the counters keep running. Writes go into an eight-byte staging buffer that records which bytes have arrived. A commit strobe moves the buffer into the counters only when all eight bytes are present. An abort strobe, or a commit with any byte missing, throws the buffer away. After reset the counters hold still until the host writes its first byte.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. At 59 the field returns to 00 and carries into the next field. The byte layout is byte 0 = seconds and byte 1 = minutes.
- R2: When hour byte bit 7 is 1 (24-hour form), bits 5:0 hold BCD hours from 00 to 23. After 23 the hour becomes 00 and the date advances.
- R3: When hour byte bit 7 is 0 (12-hour form), bits 4:0 hold BCD hours from 01 to 12 and bit 5 is the PM flag. The hour after 12 is 01. The step from 11 to 12 toggles the PM flag, and that step advances the date only when the flag was set before it.
- R4: The date (byte 3) returns to 01 after the last day of the month and carries into the month (byte 4, 01 to 12). Month 12 returns to 01 and carries into the year (byte 5, 00 to 99). Year 99 returns to 00 and carries into the century (byte 7).
- R5: February has 29 days in every year whose value is divisible by four, including 00, and 28 days in all other years.
- R6: The day of week (byte 6) counts 0 to 6, returns to 0 after 6, and advances once each time the date advances.
- R7: A snapshot strobe copies all eight live bytes into a latch on the next clock edge. The read port returns latch byte rd_addr, and the latch does not change while seconds tick until the next snapshot.
- R8: A write stores its byte in the staging buffer at wr_addr. A commit with all eight bytes written since the last commit or abort loads them into the counters on the next clock edge.
- R9: An abort, or a commit with fewer than eight bytes written, empties the staging buffer and leaves the counters unchanged. A write in the same cycle as a commit or abort is dropped.
- R10: After a commit the counters hold the committed value until the next tick, which advances that value by one second.
- R11: After reset the counters hold at 00:00:00 in 24-hour form, 01/01/00, day 0, century 20, and they ignore ticks until the first write. From that write on, running reads 1 and stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Write one byte into the staging buffer |
| wr_addr | input | 3 | Byte index for writes |
| wr_data | input | 8 | Byte written |
| commit | input | 1 | End-of-write strobe; loads the buffer only if it is complete |
| abort | input | 1 | Discards the staging buffer |
| snap | input | 1 | Copies the live time into the read latch |
| rd_addr | input | 3 | Byte index into the read latch |
| rd_data | output | 8 | Latched byte at rd_addr |
| running | output | 1 | High once counting is enabled |

## Verification
Every state change takes exactly one register stage. A tick, a commit or a snapshot driven before a rising edge shows in the counters or in the latch right after that edge. Because rd_data is combinational from the latch, a snapshot taken in the cycle after a tick or commit already shows the result. The bench drives on falling edges and reads the latch between edges, so every check samples one cycle after its stimulus. Year and month are swept completely at the end of each month, and the seconds and hour fields are swept step by step. Expected values come from day-count and modulo arithmetic.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = 8;
    localparam int IDX_W   = $clog2(NBYTES);
    localparam int OFS_W   = IDX_W + $clog2(BYTE_W);
    localparam int TIME_W  = BYTE_W * NBYTES;
    localparam int H24_BIT = 7;
    localparam int PM_BIT  = 5;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] dow;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return {v[7:4], v[3:0] + 4'h1};
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return {3'b000, v[7:4]} * 7'd10 + {3'b000, v[3:0]};
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mo, input logic [7:0] yr);
        logic [6:0] y;
        y = bcd_to_bin(yr);
        case (mo)
            8'h02:                      return (y[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_stage_buf.sv
module rtc_stage_buf
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             commit,
    input  logic             abort,
    output rtc_time_t        staged,
    output logic             commit_ok
);
    typedef struct packed {
        logic [TIME_W-1:0] data;
        logic [NBYTES-1:0] valid;
    } stage_st_t;

    stage_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit || abort) begin
            st_d.valid = '0;
        end else if (wr_en) begin
            st_d.data[{wr_addr, 3'b000} +: BYTE_W] = wr_data;
            st_d.valid[wr_addr] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign staged    = rtc_time_t'(st_q.data);
    assign commit_ok = commit && (&st_q.valid);

    p_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit || abort) |=> (st_q.valid == '0));
    p_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !commit && !abort) |=> st_q.valid[$past(wr_addr)]);
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter logic [7:0] RESET_CENT = 8'h20,
    parameter bit         RESET_24H  = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      run,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now
);
    localparam rtc_time_t RESET_TIME = '{
        cent: RESET_CENT, dow: 8'h00, year: 8'h00, month: 8'h01,
        date: 8'h01, hour: (RESET_24H ? 8'h80 : 8'h12), min: 8'h00, sec: 8'h00};

    rtc_time_t now_d, now_q;
    logic       step, c_sec, c_min, c_day, c_mon, c_yr;
    logic [7:0] hr_tmp;

    assign step = tick && run && !load;

    always_comb begin
        now_d  = now_q;
        c_sec  = 1'b0;
        c_min  = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_yr   = 1'b0;
        hr_tmp = '0;
        if (load) begin
            now_d = load_val;
        end else if (step) begin
            c_sec     = (now_q.sec == 8'h59);
            now_d.sec = c_sec ? 8'h00 : bcd_inc(now_q.sec);
            if (c_sec) begin
                c_min     = (now_q.min == 8'h59);
                now_d.min = c_min ? 8'h00 : bcd_inc(now_q.min);
            end
            if (c_min) begin
                if (now_q.hour[H24_BIT]) begin
                    hr_tmp = bcd_inc({2'b00, now_q.hour[5:0]});
                    if (now_q.hour[5:0] == 6'h23) begin
                        now_d.hour = 8'h80;
                        c_day      = 1'b1;
                    end else begin
                        now_d.hour = {2'b10, hr_tmp[5:0]};
                    end
                end else begin
                    hr_tmp = bcd_inc({3'b000, now_q.hour[4:0]});
                    if (now_q.hour[4:0] == 5'h12) begin
                        now_d.hour = {2'b00, now_q.hour[PM_BIT], 5'h01};
                    end else if (now_q.hour[4:0] == 5'h11) begin
                        now_d.hour = {2'b00, ~now_q.hour[PM_BIT], 5'h12};
                        c_day      = now_q.hour[PM_BIT];
                    end else begin
                        now_d.hour = {2'b00, now_q.hour[PM_BIT], hr_tmp[4:0]};
                    end
                end
            end
            if (c_day) begin
                now_d.dow = (now_q.dow == 8'h06) ? 8'h00 : now_q.dow + 8'h01;
                c_mon     = (now_q.date == last_day(now_q.month, now_q.year));
                now_d.date = c_mon ? 8'h01 : bcd_inc(now_q.date);
            end
            if (c_mon) begin
                c_yr        = (now_q.month == 8'h12);
                now_d.month = c_yr ? 8'h01 : bcd_inc(now_q.month);
            end
            if (c_yr) begin
                now_d.year = (now_q.year == 8'h99) ? 8'h00 : bcd_inc(now_q.year);
                if (now_q.year == 8'h99)
                    now_d.cent = (now_q.cent == 8'h99) ? 8'h00 : bcd_inc(now_q.cent);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) now_q <= RESET_TIME;
        else        now_q <= now_d;
    end

    assign now = now_q;

    p_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(now_q));
    p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && now_q.sec == 8'h59) |=> (now_q.sec == 8'h00));
    p_min_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && now_q.sec != 8'h59) |=> $stable(now_q.min));
    p_h24_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && now_q.sec == 8'h59 && now_q.min == 8'h59 && now_q.hour == 8'hA3)
        |=> (now_q.hour == 8'h80));
    p_pm_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && now_q.sec == 8'h59 && now_q.min == 8'h59 && !now_q.hour[H24_BIT]
         && now_q.hour[4:0] == 5'h11)
        |=> (now_q.hour[PM_BIT] != $past(now_q.hour[PM_BIT])));
    p_month_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_day && now_q.date == last_day(now_q.month, now_q.year)) |=> (now_q.date == 8'h01));
    p_dow_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_day |=> (now_q.dow != $past(now_q.dow)));
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (now_q == $past(load_val)));
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap,
    input  rtc_time_t        live,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [7:0]       rd_data
);
    logic [TIME_W-1:0] snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (snap) snap_d = live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    logic [OFS_W-1:0] rd_ofs;
    assign rd_ofs  = {rd_addr, 3'b000};
    assign rd_data = snap_q[rd_ofs +: BYTE_W];

    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (snap_q == $past(live)));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(snap_q));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter logic [7:0] RESET_CENT = 8'h20,
    parameter bit         RESET_24H  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1hz,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             commit,
    input  logic             abort,
    input  logic             snap,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic             running
);
    rtc_time_t staged, live;
    logic      commit_ok;
    logic      run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (wr_en) run_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end

    assign running = run_q;

    rtc_stage_buf u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(commit), .abort(abort),
        .staged(staged), .commit_ok(commit_ok)
    );

    rtc_time_core #(.RESET_CENT(RESET_CENT), .RESET_24H(RESET_24H)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .run(run_q),
        .load(commit_ok), .load_val(staged), .now(live)
    );

    rtc_snapshot u_snap (
        .clk(clk), .rst_n(rst_n), .snap(snap), .live(live),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    p_run_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> run_q);
    p_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_ok && !(tick_1hz && run_q)) |=> $stable(live));
endmodule

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0, wr_en = 1'b0, commit = 1'b0, abort = 1'b0, snap = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       running;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_calendar dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit), .abort(abort),
        .snap(snap), .rd_addr(rd_addr), .rd_data(rd_data), .running(running)
    );

    function automatic logic [7:0] bcd(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [63:0] mk(input logic [7:0] s, mi, h, d, mo, y, w, c);
        return {c, w, y, mo, d, h, mi, s};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [63:0] t);
        for (int i = 0; i < 8; i++) wr(i, t[i*8 +: 8]);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic tick();
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic read_latch(output logic [63:0] t);
        for (int i = 0; i < 8; i++) begin
            rd_addr = 3'(i);
            #0.1;
            t[i*8 +: 8] = rd_data;
        end
    endtask

    task automatic snap_read(output logic [63:0] t);
        snap = 1'b1;
        @(negedge clk);
        snap = 1'b0;
        read_latch(t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] got, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: halted after reset, reset values
        chk("R11 running", {63'd0, running}, 64'd0);
        repeat (3) tick();
        snap_read(got);
        chk("R11 reset", got, mk(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20));
        wr(0, 8'h45);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        chk("R11 running", {63'd0, running}, 64'd1);
        snap_read(got);
        chk("R9 abort keeps", got, mk(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20));
        tick();
        snap_read(got);
        chk("R11 starts", got, mk(8'h01, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20));

        // R8/R10: commit visible, then advances
        base = mk(8'h30, 8'h14, 8'h89, 8'h17, 8'h06, 8'h42, 8'h03, 8'h20);
        load(base);
        snap_read(got);
        chk("R8 commit", got, base);
        tick();
        snap_read(got);
        chk("R10 advance", got, mk(8'h31, 8'h14, 8'h89, 8'h17, 8'h06, 8'h42, 8'h03, 8'h20));
        base = got;

        // R9: incomplete commit and abort-then-commit
        for (int i = 0; i < 7; i++) wr(i, 8'h11);
        commit = 1'b1; @(negedge clk); commit = 1'b0;
        snap_read(got);
        chk("R9 partial", got, base);
        for (int i = 0; i < 8; i++) wr(i, 8'h22);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        commit = 1'b1; @(negedge clk); commit = 1'b0;
        snap_read(got);
        chk("R9 abort", got, base);

        // R7: latch holds while time runs
        repeat (5) tick();
        read_latch(got);
        chk("R7 held", got, base);
        snap_read(got);
        chk("R7 resnap", got, mk(8'h36, 8'h14, 8'h89, 8'h17, 8'h06, 8'h42, 8'h03, 8'h20));

        // R1: seconds/minutes sweep
        load(mk(8'h00, 8'h00, 8'h80, 8'h05, 8'h05, 8'h05, 8'h00, 8'h20));
        for (int n = 1; n <= 3700; n++) begin
            tick();
            snap_read(got);
            chk("R1 sweep", got, mk(bcd(n % 60), bcd((n / 60) % 60), 8'h80 | bcd(n / 3600),
                                     8'h05, 8'h05, 8'h05, 8'h00, 8'h20));
        end

        // R2: 24-hour sweep
        for (int h = 0; h < 24; h++) begin
            load(mk(8'h59, 8'h59, 8'h80 | bcd(h), 8'h15, 8'h03, 8'h10, 8'h02, 8'h20));
            tick();
            snap_read(got);
            chk("R2 hour", got, mk(8'h00, 8'h00, 8'h80 | bcd((h + 1) % 24),
                                    (h == 23) ? 8'h16 : 8'h15, 8'h03, 8'h10,
                                    (h == 23) ? 8'h03 : 8'h02, 8'h20));
        end

        // R3: 12-hour sweep
        for (int pm = 0; pm < 2; pm++) begin
            for (int h = 1; h <= 12; h++) begin
                int nh, npm, cd;
                nh  = (h == 12) ? 1 : h + 1;
                npm = (h == 11) ? 1 - pm : pm;
                cd  = (h == 11 && pm == 1) ? 1 : 0;
                load(mk(8'h59, 8'h59, {2'b00, 1'(pm), bcd(h)[4:0]}, 8'h15, 8'h03, 8'h10, 8'h02, 8'h20));
                tick();
                snap_read(got);
                chk("R3 hour", got, mk(8'h00, 8'h00, {2'b00, 1'(npm), bcd(nh)[4:0]},
                                        bcd(15 + cd), 8'h03, 8'h10, bcd(2 + cd), 8'h20));
            end
        end

        // R4/R5/R6: month-end sweep over every year and month
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                int w, ld, ny, nm;
                w  = (y * 12 + m) % 7;
                ld = dim(m, y);
                nm = (m == 12) ? 1 : m + 1;
                ny = (m == 12) ? (y + 1) % 100 : y;
                load(mk(8'h59, 8'h59, 8'hA3, bcd(ld), bcd(m), bcd(y), 8'(w), 8'h20));
                tick();
                snap_read(got);
                chk((m == 2) ? "R5 feb end" : "R4 month end", got,
                    mk(8'h00, 8'h00, 8'h80, 8'h01, bcd(nm), bcd(ny), 8'((w + 1) % 7),
                       (m == 12 && y == 99) ? 8'h21 : 8'h20));
                chk("R6 dow", {56'd0, got[55:48]}, {56'd0, 8'((w + 1) % 7)});
                if (m == 2) begin
                    load(mk(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, bcd(y), 8'h06, 8'h20));
                    tick();
                    snap_read(got);
                    chk("R5 feb28", got, mk(8'h00, 8'h00, 8'h80, (y % 4 == 0) ? 8'h29 : 8'h01,
                                             (y % 4 == 0) ? 8'h02 : 8'h03, bcd(y), 8'h00, 8'h20));
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule